// File: doc/BRIEF.md
# Streamed-Load Ramp Profile RAM

This block holds the amplitude profile that a ramp sequencer steps through to shape the rising and falling edges of a DAC burst. The table has 64 entries of 10 bits. After a synchronous reset it holds a raised-cosine curve that climbs from 0 at index 0 to full scale at index 63. The sequencer fetches any entry by index through a registered read port.

A host changes the profile through two register writes. A control write with the load-enable bit set opens a load session and sets an internal fill pointer back to zero. Each data-register write during the session stores its low 10 bits at the pointer, and the pointer then moves forward one place. Because of this, the host can stream writes on consecutive cycles without sending any address. A control write with the load-enable bit cleared closes the session.

Top module: `ramp_profile_ram`

## Requirements
- R1: After synchronous reset, entry n holds round(511.5 × (1 − cos(nπ/63))). Examples: entry 0 = 0x000, entry 1 = 0x001, entry 4 = 0x00A, entry 32 = 0x20C, entry 63 = 0x3FF.
- R2: A cycle with `ctrl_wr` high and `ctrl_data[7]` = 1 enters load mode and sets the fill pointer to 0.
- R3: In load mode, every cycle with `data_wr` high stores a word at the fill pointer and advances the pointer by one. Writes on consecutive cycles are all accepted, so 64 writes fill entries 0 to 63 in order.
- R4: Only `data_in[9:0]` is stored. Bits 15:10 have no effect on the stored value.
- R5: Outside load mode, `data_wr` has no effect on the table.
- R6: After 64 words have been accepted in one session, further data writes are ignored. The pointer does not wrap until load mode is entered again.
- R7: A cycle with `ctrl_wr` high and `ctrl_data[7]` = 0 leaves load mode. Data writes after it are ignored.
- R8: `rd_data` shows the entry at `rd_idx` one clock after the index is presented. A word written in cycle t to the entry being read appears in `rd_data` from cycle t+1 onward; the read in cycle t returns the old value.
- R9: When `ctrl_wr` and `data_wr` are high in the same cycle, the control write takes effect and the data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; reloads the default table |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control write data; bit 7 is the load enable |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 16 | Data write word; bits 9:0 are stored |
| rd_idx | input | 6 | Read index from the ramp sequencer |
| rd_data | output | 10 | Registered table entry |

## Verification
The assertions check the session state and the pointer on every cycle:
- A control write opens or closes the session.
- Each accepted word moves the pointer forward exactly one place.
- The pointer stays at its terminal count until load mode is entered again, and never exceeds it.
- The pointer is frozen outside load mode.

The bench's scenarios are the only check of the table contents themselves. They show the computed reset profile and the address order of a streamed fill. They also show that reserved bits, writes outside a session and writes after the table is full all leave the table unchanged. Finally, they check the old-then-new timing when the sequencer reads an entry in the same cycle it is written.

// File: rtl/ramp_profile_ram.sv
module ramp_profile_ram #(
  parameter int DEPTH    = 64,
  parameter int WIDTH    = 10,
  parameter int REG_W    = 16,
  parameter int CTRL_W   = 8,
  parameter int LOAD_BIT = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctrl_wr,
  input  logic [CTRL_W-1:0]        ctrl_data,
  input  logic                     data_wr,
  input  logic [REG_W-1:0]         data_in,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [WIDTH-1:0]         rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  function automatic logic [DEPTH*WIDTH-1:0] build_profile();
    logic [DEPTH*WIDTH-1:0] t;
    real half, v;
    half = ((2.0 ** WIDTH) - 1.0) / 2.0;
    t = '0;
    for (int n = 0; n < DEPTH; n++) begin
      v = half * (1.0 - $cos(3.14159265358979 * n / (DEPTH - 1)));
      t[n*WIDTH +: WIDTH] = WIDTH'($rtoi(v + 0.5));
    end
    return t;
  endfunction

  localparam logic [DEPTH*WIDTH-1:0] PROFILE = build_profile();

  logic [WIDTH-1:0] mem [DEPTH];
  logic             load_q;
  logic [PW-1:0]    ptr;
  logic             accept;
  logic             unused_bits;

  assign accept      = data_wr && !ctrl_wr && load_q && (ptr != FULL);
  assign unused_bits = ^{ctrl_data, data_in[REG_W-1:WIDTH]};

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      ptr    <= '0;
    end else if (ctrl_wr) begin
      load_q <= ctrl_data[LOAD_BIT];
      if (ctrl_data[LOAD_BIT]) ptr <= '0;
    end else if (accept) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < DEPTH; n++) mem[n] <= PROFILE[n*WIDTH +: WIDTH];
    end else if (accept) begin
      mem[ptr[AW-1:0]] <= data_in[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk) rd_data <= mem[rd_idx];
endmodule

module ramp_profile_ram_chk #(
  parameter int PW = 7,
  parameter int DEPTH = 64,
  parameter int CTRL_W = 8,
  parameter int LOAD_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_data,
  input logic              data_wr,
  input logic              load_q,
  input logic [PW-1:0]     ptr
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  p_enter_clears_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && ctrl_data[LOAD_BIT] |=> load_q && ptr == '0);

  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr && data_wr && load_q && ptr != FULL |=> ptr == $past(ptr) + 1'b1);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    ptr == FULL && !(ctrl_wr && ctrl_data[LOAD_BIT]) |=> ptr == FULL);

  p_exit_load_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !ctrl_data[LOAD_BIT] |=> !load_q);

  p_idle_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !load_q && !ctrl_wr |=> $stable(ptr) && !load_q);

  p_ctrl_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && data_wr && ctrl_data[LOAD_BIT] |=> ptr == '0);

  always_comb if (!rst) p_ptr_bound_r6: assert (ptr <= FULL);
endmodule

bind ramp_profile_ram ramp_profile_ram_chk #(
  .PW(PW), .DEPTH(DEPTH), .CTRL_W(CTRL_W), .LOAD_BIT(LOAD_BIT)
) chk_i (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
  .data_wr(data_wr), .load_q(load_q), .ptr(ptr)
);

// File: tb/ramp_profile_ram_tb.sv
module ramp_profile_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_data = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data_in = '0;
  logic [5:0]  rd_idx = '0;
  logic [9:0]  rd_data;

  int checks = 0;
  int fails = 0;
  logic [9:0] exp_t [64];

  always #10 clk = ~clk;

  ramp_profile_ram dut_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .data_wr(data_wr), .data_in(data_in), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [9:0] cosine_entry(int n);
    real v;
    v = 511.5 * (1.0 - $cos(3.14159265358979 * n / 63.0));
    return 10'($rtoi(v + 0.5));
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic read_chk(string req, int idx);
    @(negedge clk) rd_idx = 6'(idx);
    @(negedge clk) check(req, rd_data, exp_t[idx]);
  endtask

  task automatic ctrl(logic en);
    @(negedge clk) begin ctrl_wr = 1'b1; ctrl_data = {en, 7'h00}; end
    @(negedge clk) ctrl_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int n = 0; n < 64; n++) exp_t[n] = cosine_entry(n);
  endtask

  task automatic t_reset_profile();
    do_reset();
    check("R1 e0", exp_t[0], 10'h000);
    check("R1 e1", exp_t[1], 10'h001);
    check("R1 e4", exp_t[4], 10'h00A);
    check("R1 e32", exp_t[32], 10'h20C);
    check("R1 e63", exp_t[63], 10'h3FF);
    for (int n = 0; n < 64; n++) read_chk("R1", n);
  endtask

  task automatic t_idle_ignored();
    @(negedge clk) begin data_wr = 1'b1; data_in = 16'h0155; end
    @(negedge clk) data_in = 16'h02AA;
    @(negedge clk) data_wr = 1'b0;
    read_chk("R5", 0);
    read_chk("R5", 1);
  endtask

  task automatic t_stream_fill();
    ctrl(1'b1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk) begin
        data_wr = 1'b1;
        data_in = {(i % 2) ? 6'h3F : 6'h00, 10'((i * 37 + 5) & 10'h3FF)};
      end
      exp_t[i] = 10'((i * 37 + 5) & 10'h3FF);
    end
    @(negedge clk) data_in = 16'h0123;
    @(negedge clk) data_in = 16'h0321;
    @(negedge clk) data_wr = 1'b0;
    for (int n = 0; n < 64; n++) read_chk((n % 2) ? "R4" : "R3", n);
    read_chk("R6", 0);
    read_chk("R6", 1);
  endtask

  task automatic t_exit();
    ctrl(1'b0);
    @(negedge clk) begin data_wr = 1'b1; data_in = 16'h03C3; end
    @(negedge clk) data_wr = 1'b0;
    read_chk("R7", 0);
    read_chk("R7", 63);
  endtask

  task automatic t_reenter();
    ctrl(1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) begin data_wr = 1'b1; data_in = 16'(10'h100 + i); end
      exp_t[i] = 10'(10'h100 + i);
    end
    @(negedge clk) data_wr = 1'b0;
    for (int n = 0; n < 4; n++) read_chk("R2", n);
  endtask

  task automatic t_ctrl_priority();
    @(negedge clk) begin
      ctrl_wr = 1'b1; ctrl_data = 8'h80; data_wr = 1'b1; data_in = 16'h0077;
    end
    @(negedge clk) begin ctrl_wr = 1'b0; data_wr = 1'b0; end
    read_chk("R9", 0);
    @(negedge clk) begin data_wr = 1'b1; data_in = 16'h0088; end
    @(negedge clk) data_wr = 1'b0;
    exp_t[0] = 10'h088;
    read_chk("R9", 0);
  endtask

  task automatic t_read_during_write();
    logic [9:0] old;
    @(negedge clk) begin data_wr = 1'b1; data_in = 16'h0200; end
    exp_t[1] = 10'h200;
    @(negedge clk) begin data_wr = 1'b1; data_in = 16'h0211; rd_idx = 6'd2; end
    old = exp_t[2];
    exp_t[2] = 10'h211;
    @(negedge clk) begin data_wr = 1'b0; check("R8 old", rd_data, old); end
    @(negedge clk) check("R8 new", rd_data, exp_t[2]);
    read_chk("R8", 1);
  endtask

  task automatic t_reset_restores();
    do_reset();
    read_chk("R1 restore", 0);
    read_chk("R1 restore", 2);
    read_chk("R1 restore", 32);
  endtask

  initial begin
    t_reset_profile();
    t_idle_ignored();
    t_stream_fill();
    t_exit();
    t_reenter();
    t_ctrl_priority();
    t_read_during_write();
    t_reset_restores();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule